// File: doc/BRIEF.md
# Multi-Master Region Access Permission Checker

This block decides, for each bus access, whether it may proceed. An access is described by the issuing master (one of four), its kind (read, write or execute), whether it runs in supervisor or user mode, its address and a process identifier. The block compares it with a parameterized set of region descriptors. Each descriptor holds an inclusive address window, a valid flag, a process identifier with a don't-care mask, and a packed permission word with one six-bit field per master.

A descriptor hits when it is valid, the address lies inside its window, and, if that master's process-identifier enable is set, the access identifier agrees with the descriptor identifier on every bit where the mask is 0. User rights are three independent bits. Supervisor rights use a two-bit code, one value of which defers to the user bits. The access is allowed if any hitting descriptor permits it, and is an error otherwise. The answer is registered one cycle after the request strobe and names the lowest-numbered descriptor that granted the access. Descriptors are loaded one word at a time through a write port.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every descriptor is invalid and the response outputs are low, so every access answers with an error until a valid descriptor has been written.
- R2: A response (`rsp_valid` high) appears exactly one clock after a cycle with `req_valid` high, and never in the clock after a cycle without a request.
- R3: A descriptor hits only when its valid flag is set and start <= address <= end, with both bounds inclusive.
- R4: In user mode a master's rights are the three low bits of its field, with bit 2 read, bit 1 write and bit 0 execute; a set bit permits that kind and a clear bit forbids it.
- R5: In supervisor mode the two-bit code in field bits 4:3 gives the rights: 00 read, write and execute; 01 read and execute; 10 read and write; 11 the same as that master's user bits.
- R6: When field bit 5 (process-identifier enable) is set, a hit also needs `((req_pid ^ pid) & ~mask) == 0`; when it is clear the process identifier has no effect.
- R7: The grant is the OR over all hitting descriptors; `rsp_desc` is the lowest index that grants; with no granting descriptor, including no hit at all, the response is an error.
- R8: Configuration words selected by `cfg_sel`: 0 start, 1 end, 2 permission word, 3 identifier word. The field of master m is permission bits [6m+5:6m]. The identifier word holds pid in bits [15:8], mask in bits [7:0] and valid in bit 31. A request in the same cycle as a write is judged against the old contents.
- R9: Access kind is coded 0 read, 1 write, 2 execute; code 3 is never granted.
- R10: With `rsp_valid` high exactly one of `rsp_grant` and `rsp_error` is high; with it low both are low; `rsp_desc` is 0 whenever no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_idx | input | 2 | Descriptor number to write |
| cfg_sel | input | 2 | Word select (0 start, 1 end, 2 permissions, 3 identifier/valid) |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Access request strobe |
| req_master | input | 2 | Issuing master |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_super | input | 1 | 1 supervisor, 0 user mode |
| req_addr | input | 32 | Access address |
| req_pid | input | 8 | Access process identifier |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_error | output | 1 | Access error |
| rsp_desc | output | 2 | Lowest granting descriptor, 0 on error |

## Verification
Every result is due one clock after the request strobe: the decision is combinational from the stored descriptors and captured in a single output register. The bench drives a request on a falling edge, lets one rising edge pass, and compares all four response outputs on the next falling edge before dropping the strobe, so each check sees exactly the registered answer to its own request. Descriptor writes finish a full cycle before any dependent request, so the old-contents rule never blurs an expected value.

// File: rtl/mpu_region_check.sv
module mpu_region_check #(
  parameter int NUM_DESC = 4,
  parameter int AW = 32,
  parameter int PIDW = 8,
  localparam int IW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int CW = (AW > 32) ? AW : 32,
  localparam int PW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [1:0]      cfg_sel,
  input  logic [CW-1:0]   cfg_data,
  input  logic            req_valid,
  input  logic [1:0]      req_master,
  input  logic [1:0]      req_type,
  input  logic            req_super,
  input  logic [AW-1:0]   req_addr,
  input  logic [PIDW-1:0] req_pid,
  output logic            rsp_valid,
  output logic            rsp_grant,
  output logic            rsp_error,
  output logic [IW-1:0]   rsp_desc
);

  logic [AW-1:0]   d_start [NUM_DESC];
  logic [AW-1:0]   d_end   [NUM_DESC];
  logic [PW-1:0]   d_perm  [NUM_DESC];
  logic [PIDW-1:0] d_pid   [NUM_DESC];
  logic [PIDW-1:0] d_mask  [NUM_DESC];
  logic [NUM_DESC-1:0] d_valid;
  logic [NUM_DESC-1:0] allow;
  logic [IW-1:0]   first_idx;
  logic            any_allow;
  logic            unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DESC; d++) begin
        d_start[d] <= '0;
        d_end[d]   <= '0;
        d_perm[d]  <= '0;
        d_pid[d]   <= '0;
        d_mask[d]  <= '0;
      end
      d_valid <= '0;
    end else if (cfg_we) begin
      for (int d = 0; d < NUM_DESC; d++) begin
        if (cfg_idx == IW'(d)) begin
          case (cfg_sel)
            2'd0: d_start[d] <= cfg_data[AW-1:0];
            2'd1: d_end[d]   <= cfg_data[AW-1:0];
            2'd2: d_perm[d]  <= cfg_data[PW-1:0];
            default: begin
              d_pid[d]   <= cfg_data[2*PIDW-1:PIDW];
              d_mask[d]  <= cfg_data[PIDW-1:0];
              d_valid[d] <= cfg_data[CW-1];
            end
          endcase
        end
      end
    end
  end

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    logic [5:0] fld;
    logic [2:0] rwx;
    logic       in_range;
    logic       pid_ok;
    logic       kind_ok;

    assign fld      = d_perm[d][6*req_master +: 6];
    assign in_range = (req_addr >= d_start[d]) && (req_addr <= d_end[d]);
    assign pid_ok   = !fld[5] || (((req_pid ^ d_pid[d]) & ~d_mask[d]) == '0);

    always_comb begin
      if (!req_super) rwx = fld[2:0];
      else begin
        case (fld[4:3])
          2'b00:   rwx = 3'b111;
          2'b01:   rwx = 3'b101;
          2'b10:   rwx = 3'b110;
          default: rwx = fld[2:0];
        endcase
      end
    end

    always_comb begin
      case (req_type)
        2'd0:    kind_ok = rwx[2];
        2'd1:    kind_ok = rwx[1];
        2'd2:    kind_ok = rwx[0];
        default: kind_ok = 1'b0;
      endcase
    end

    assign allow[d] = d_valid[d] && in_range && pid_ok && kind_ok;
  end

  assign any_allow = |allow;

  always_comb begin
    first_idx = '0;
    for (int i = NUM_DESC - 1; i >= 0; i--)
      if (allow[i]) first_idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_error <= 1'b0;
      rsp_desc  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && any_allow;
      rsp_error <= req_valid && !any_allow;
      rsp_desc  <= (req_valid && any_allow) ? first_idx : '0;
    end
  end

endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic          cfg_vbit,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic          rsp_grant,
  input logic          rsp_error,
  input logic [IW-1:0] rsp_desc
);

  logic programmed;

  always_ff @(posedge clk) begin
    if (!rst_n) programmed <= 1'b0;
    else if (cfg_we && cfg_sel == 2'd3 && cfg_vbit) programmed <= 1'b1;
  end

  assert_unprogrammed_errors_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !programmed) |-> rsp_error);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant ^ rsp_error));

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_grant || rsp_error));

  assert_desc_zero_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_grant |-> (rsp_desc == '0));

endmodule

bind mpu_region_check mpu_region_check_sva #(.IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_vbit(cfg_data[CW-1]), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_error(rsp_error), .rsp_desc(rsp_desc)
);

// File: tb/test_mpu_region_check.sv
module test_mpu_region_check;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_master = '0;
  logic [1:0] req_type = '0;
  logic req_super = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0] req_pid = '0;
  logic rsp_valid, rsp_grant, rsp_error;
  logic [1:0] rsp_desc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_start [ND];
  logic [31:0] m_end   [ND];
  logic [23:0] m_perm  [ND];
  logic [7:0]  m_pid   [ND];
  logic [7:0]  m_mask  [ND];
  bit          m_valid [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_check i_mpu_region_check (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_master(req_master),
    .req_type(req_type), .req_super(req_super), .req_addr(req_addr), .req_pid(req_pid),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_error(rsp_error), .rsp_desc(rsp_desc)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, int sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel = 2'(sel); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_desc(int d, logic [31:0] s, logic [31:0] e, logic [23:0] p,
                          logic [7:0] pid, logic [7:0] mask, bit v);
    wr(d, 0, s); wr(d, 1, e); wr(d, 2, {8'h00, p});
    wr(d, 3, {v, 15'h0, pid, mask});
    m_start[d] = s; m_end[d] = e; m_perm[d] = p; m_pid[d] = pid; m_mask[d] = mask; m_valid[d] = v;
  endtask

  function automatic logic [23:0] pack(logic [5:0] f0, logic [5:0] f1, logic [5:0] f2, logic [5:0] f3);
    return {f3, f2, f1, f0};
  endfunction

  function automatic bit permits(logic [5:0] f, bit sup, int typ);
    logic [2:0] r;
    if (!sup) r = f[2:0];
    else if (f[4:3] == 2'b00) r = 3'b111;
    else if (f[4:3] == 2'b01) r = 3'b101;
    else if (f[4:3] == 2'b10) r = 3'b110;
    else r = f[2:0];
    if (typ == 0) return r[2];
    if (typ == 1) return r[1];
    if (typ == 2) return r[0];
    return 1'b0;
  endfunction

  function automatic int expect_idx(int m, bit sup, int typ, logic [31:0] a, logic [7:0] pid);
    for (int d = 0; d < ND; d++) begin
      logic [5:0] f;
      f = m_perm[d][6*m +: 6];
      if (m_valid[d] && a >= m_start[d] && a <= m_end[d] &&
          (!f[5] || ((pid ^ m_pid[d]) & ~m_mask[d]) == 8'h00) && permits(f, sup, typ))
        return d;
    end
    return -1;
  endfunction

  task automatic access(string tag, int m, bit sup, int typ, logic [31:0] a, logic [7:0] pid);
    int e;
    e = expect_idx(m, sup, typ, a, pid);
    @(negedge clk);
    req_valid = 1'b1; req_master = 2'(m); req_super = sup; req_type = 2'(typ);
    req_addr = a; req_pid = pid;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_grant !== (e >= 0) || rsp_error !== (e < 0) ||
        rsp_desc !== ((e >= 0) ? 2'(e) : 2'd0)) begin
      fails++;
      $display("FAIL %s: m%0d s%0d t%0d a=%h pid=%h actual v%0b g%0b e%0b d%0d expected g%0b d%0d",
               tag, m, sup, typ, a, pid, rsp_valid, rsp_grant, rsp_error, rsp_desc, e >= 0,
               (e >= 0) ? e : 0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < ND; d++) begin
      m_start[d] = 0; m_end[d] = 0; m_perm[d] = 0; m_pid[d] = 0; m_mask[d] = 0; m_valid[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 rsp_grant", 32'(rsp_grant), 0);
    check("R1 rsp_error", 32'(rsp_error), 0);
    for (int m = 0; m < 4; m++) access("R1 unprogrammed", m, 1, 0, 32'h0, 8'h00);
    // R2: no request, no response
    repeat (2) @(negedge clk);
    check("R2 idle", 32'(rsp_valid), 0);

    // R4 R5 R8 R9: permission code sweep
    for (int c = 0; c < 64; c++) begin
      set_desc(0, 32'h1000, 32'h1FFF,
               pack(6'(c), 6'((c + 13) % 64), 6'((c + 26) % 64), 6'((c + 39) % 64)),
               8'h00, 8'hFF, 1);
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 4; t++)
            access("R4_R5_R8_R9 rights", m, s[0], t, 32'h1800, 8'(c));
    end

    // R3: inclusive bounds and valid flag
    set_desc(0, 32'h2000, 32'h20FF, pack(6'o07, 6'o07, 6'o07, 6'o07), 8'h0, 8'h0, 1);
    foreach (m_start[i]) ;
    access("R3 below", 0, 0, 0, 32'h1FFF, 8'h0);
    access("R3 start", 0, 0, 0, 32'h2000, 8'h0);
    access("R3 end",   1, 0, 1, 32'h20FF, 8'h0);
    access("R3 above", 1, 0, 1, 32'h2100, 8'h0);
    access("R3 zero",  2, 0, 2, 32'h0, 8'h0);
    access("R3 max",   3, 0, 2, 32'hFFFF_FFFF, 8'h0);
    set_desc(0, 32'h2000, 32'h20FF, pack(6'o07, 6'o07, 6'o07, 6'o07), 8'h0, 8'h0, 0);
    access("R3 invalid", 0, 0, 0, 32'h2010, 8'h0);

    // R6: process identifier with mask
    set_desc(0, 32'h0, 32'hFFFF, pack(6'o47, 6'o07, 6'o07, 6'o47), 8'hA5, 8'h0F, 1);
    for (int p = 0; p < 256; p++) begin
      access("R6 pe set", 0, 0, 0, 32'h100, 8'(p));
      access("R6 pe clear", 1, 0, 0, 32'h100, 8'(p));
    end
    access("R6 pe set sup", 3, 1, 1, 32'h100, 8'hA0);
    access("R6 pe set miss", 3, 1, 1, 32'h100, 8'h25);

    // R7: overlap, OR and lowest granting index
    set_desc(0, 32'h0,   32'hFFFF, pack(6'o04, 6'o04, 6'o04, 6'o04), 8'h0, 8'h0, 1);
    set_desc(1, 32'h100, 32'h1FF,  pack(6'o06, 6'o06, 6'o06, 6'o06), 8'h0, 8'h0, 1);
    set_desc(2, 32'h180, 32'h2FF,  pack(6'o07, 6'o07, 6'o07, 6'o07), 8'h0, 8'h0, 1);
    set_desc(3, 32'h0,   32'hFFFF, pack(6'o30, 6'o30, 6'o30, 6'o30), 8'h0, 8'h0, 1);
    for (int k = 0; k < 8; k++)
      for (int t = 0; t < 4; t++)
        for (int s = 0; s < 2; s++)
          access("R7 overlap", 2, s[0], t, 32'h80 * k + 32'h40, 8'h0);
    access("R7 no hit", 0, 1, 0, 32'h10000, 8'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule